// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Initialisation

This block keeps a 64K-bit dynamic RAM alive. It counts out a refresh interval so that all 128 rows are visited once in every refresh window. Each refresh is a RAS-only cycle: the block drives the row address and pulses RAS itself while CAS stays high. It does not own the memory bus outright. When a refresh is due, it raises `refresh_req` towards the access sequencer and waits for `refresh_gnt`. Only then does it take the bus, run the pulse and advance its 7-bit row counter.

After reset the block holds the memory closed for the power-up pause. It then runs eight warm-up RAS cycles on its own and raises `ready`. The access sequencer must not grant host traffic before `ready` is high. Every timing value is given in nanoseconds and turned into clock cycles from `CLK_PERIOD_NS`, rounded up. The refresh interval is rounded down.

The request/grant pair is a valid/ready handshake:
- `refresh_req` plays the part of valid. `refresh_gnt` plays the part of ready.
- A refresh is accepted on a rising clock edge where both are high.
- Once raised, `refresh_req` stays high until it is accepted. The sequencer may hold off for as long as it likes.
- Intervals that pass during that wait are counted, up to `PEND_MAX`. Intervals beyond that limit are dropped.

Top module: `dram_refresh_sched`

## Requirements
- R1: After `ready` rises, one refresh falls due every INTERVAL = floor(REFRESH_WINDOW_NS/ROWS/CLK_PERIOD_NS) cycles, the first INTERVAL cycles after `ready` rises. `refresh_req` is high exactly when at least one due refresh is outstanding and `bus_own` is low.
- R2: Once high, `refresh_req` stays high until a cycle in which `refresh_gnt` is also high.
- R3: `refresh_gnt` while `refresh_req` is low has no effect: `bus_own` only rises in the cycle after an accepted handshake (once `ready` is high).
- R4: While `bus_own` is high, `row_addr` does not change.
- R5: Each RAS-only refresh after `ready` drives the current row on `row_addr[6:0]`, with `row_addr[7]` = 0. The first row is 0. The row advances by one after each refresh and wraps from 127 to 0.
- R6: Each RAS cycle has three phases in order. `bus_own` is high with `ras_n` high for SETUP = ceil(CAS_PRE_NS/period) cycles. `ras_n` is then low for LOW = max(ceil(RAS_LOW_NS/period), ceil(RAS_CYCLE_NS/period) − PRE) cycles. Finally `ras_n` is high with `bus_own` still high for PRE = ceil(RAS_PRE_NS/period) cycles.
- R7: `refresh_req` is never high while `ready` is low.
- R8: After reset, no RAS pulse starts before PAUSE = ceil(INIT_PAUSE_NS/period) cycles have passed. Exactly WARMUP_PULSES RAS pulses occur before `ready` rises. `ready` never falls again until reset.
- R9: At most PEND_MAX due refreshes are held. When the grant is withheld for longer than that, the surplus intervals are dropped.
- R10: During reset: `ras_n`=1, `ready`=0, `refresh_req`=0, `bus_own`=0, `row_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_PERIOD_NS |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_gnt | input | 1 | Sequencer hands the bus to the refresh cycle |
| refresh_req | output | 1 | A refresh is due and the block is idle |
| ready | output | 1 | Start-up sequence complete; host traffic allowed |
| bus_own | output | 1 | Block drives address and RAS; CAS must be held high |
| ras_n | output | 1 | Row strobe, active low |
| row_addr | output | ADDR_W | Row address for the refresh or warm-up cycle |

## Verification
Every cycle, the in-line assertions check four things:
- the pending count stays within its cap, and a tick always leaves a refresh outstanding;
- the request is held and is never raised before `ready`;
- `ready` is sticky and the address is steady while the bus is owned;
- every RAS fall is preceded by an owned cycle, and every rise is followed by one.

Other behaviour can only be shown by the bench scenarios, against a cycle model of the due count. These cover the exact phase lengths, the warm-up count, the row sequence across the 127-to-0 wrap, and the dropping of surplus intervals under a long stall. They also show that stray grants are ignored.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_PRE} pulse_ph_t;
  typedef enum logic [1:0] {ST_PAUSE, ST_WARM, ST_RUN} boot_st_t;

  function automatic int ns_to_cyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dram_ref_interval.sv
module dram_ref_interval #(
  parameter int INTERVAL_CYC = 1953,
  parameter int PEND_MAX     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic take,
  output logic pend_nz
);
  localparam int CW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam int PW = $clog2(PEND_MAX + 1);

  logic [CW-1:0] tmr;
  logic [PW-1:0] pend;
  logic          tick;

  assign tick    = en && (tmr == CW'(INTERVAL_CYC - 1));
  assign pend_nz = (pend != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !en || tick) tmr <= '0;
    else                       tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                       pend <= '0;
    else if (tick && !take && pend != PW'(PEND_MAX))  pend <= pend + 1'b1;
    else if (take && !tick)                           pend <= pend - 1'b1;
  end

  // R9
  pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(PEND_MAX));
  // R1
  tick_leaves_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pend_nz);
  // R1
  take_needs_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend_nz);
endmodule

// File: rtl/dram_ref_pulse.sv
module dram_ref_pulse
  import dram_ref_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int LOW_CYC   = 22,
  parameter int PRE_CYC   = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic ras_n,
  output logic done
);
  localparam int CW = $clog2(max2(max2(SETUP_CYC, LOW_CYC), PRE_CYC) + 1);

  pulse_ph_t     ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      case (ph)
        PH_IDLE:  if (start) begin ph <= PH_SETUP; cnt <= '0; end
        PH_SETUP: if (cnt == CW'(SETUP_CYC - 1)) begin ph <= PH_LOW; cnt <= '0; end
                  else cnt <= cnt + 1'b1;
        PH_LOW:   if (cnt == CW'(LOW_CYC - 1)) begin ph <= PH_PRE; cnt <= '0; end
                  else cnt <= cnt + 1'b1;
        default:  if (cnt == CW'(PRE_CYC - 1)) begin ph <= PH_IDLE; cnt <= '0; end
                  else cnt <= cnt + 1'b1;
      endcase
    end
  end

  assign busy  = (ph != PH_IDLE);
  assign ras_n = (ph != PH_LOW);
  assign done  = (ph == PH_PRE) && (cnt == CW'(PRE_CYC - 1));

  // R6
  setup_before_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(busy));
  // R6
  pre_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> busy);
  // R6
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/dram_ref_rowctr.sv
module dram_ref_rowctr #(
  parameter int ROW_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (!rst_n)   row <= '0;
    else if (adv) row <= row + 1'b1;
  end

  // R5
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> row == ROW_W'($past(row) + 1'b1));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int CLK_PERIOD_NS     = 8,
  parameter int REFRESH_WINDOW_NS = 2_000_000,
  parameter int ROWS              = 128,
  parameter int ADDR_W            = 8,
  parameter int INIT_PAUSE_NS     = 100_000,
  parameter int WARMUP_PULSES     = 8,
  parameter int RAS_LOW_NS        = 170,
  parameter int RAS_PRE_NS        = 100,
  parameter int RAS_CYCLE_NS      = 270,
  parameter int CAS_PRE_NS        = 10,
  parameter int PEND_MAX          = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh_gnt,
  output logic              refresh_req,
  output logic              ready,
  output logic              bus_own,
  output logic              ras_n,
  output logic [ADDR_W-1:0] row_addr
);
  localparam int ROW_W        = $clog2(ROWS);
  localparam int INTERVAL_CYC = (REFRESH_WINDOW_NS / ROWS) / CLK_PERIOD_NS;
  localparam int PAUSE_CYC    = max2(ns_to_cyc(INIT_PAUSE_NS, CLK_PERIOD_NS), 1);
  localparam int SETUP_CYC    = max2(ns_to_cyc(CAS_PRE_NS, CLK_PERIOD_NS), 1);
  localparam int PRE_CYC      = max2(ns_to_cyc(RAS_PRE_NS, CLK_PERIOD_NS), 1);
  localparam int LOW_CYC      = max2(ns_to_cyc(RAS_LOW_NS, CLK_PERIOD_NS),
                                     ns_to_cyc(RAS_CYCLE_NS, CLK_PERIOD_NS) - PRE_CYC);
  localparam int PCW          = $clog2(PAUSE_CYC + 1);
  localparam int WCW          = max2($clog2(WARMUP_PULSES), 1);

  boot_st_t         state;
  logic [PCW-1:0]   pause_cnt;
  logic [WCW-1:0]   warm_cnt;
  logic             busy, done, pend_nz, take, start;
  logic [ROW_W-1:0] row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_PAUSE;
      pause_cnt <= '0;
      warm_cnt  <= '0;
    end else begin
      case (state)
        ST_PAUSE: if (pause_cnt == PCW'(PAUSE_CYC - 1)) state <= ST_WARM;
                  else pause_cnt <= pause_cnt + 1'b1;
        ST_WARM:  if (done) begin
                    if (warm_cnt == WCW'(WARMUP_PULSES - 1)) state <= ST_RUN;
                    else warm_cnt <= warm_cnt + 1'b1;
                  end
        default:  state <= ST_RUN;
      endcase
    end
  end

  assign ready       = (state == ST_RUN);
  assign refresh_req = ready && pend_nz && !busy;
  assign take        = refresh_req && refresh_gnt;
  assign start       = take || (state == ST_WARM && !busy);
  assign bus_own     = busy;
  assign row_addr    = {{(ADDR_W - ROW_W){1'b0}}, row};

  dram_ref_interval #(.INTERVAL_CYC(INTERVAL_CYC), .PEND_MAX(PEND_MAX)) u_interval (
    .clk(clk), .rst_n(rst_n), .en(ready), .take(take), .pend_nz(pend_nz));

  dram_ref_pulse #(.SETUP_CYC(SETUP_CYC), .LOW_CYC(LOW_CYC), .PRE_CYC(PRE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .ras_n(ras_n), .done(done));

  dram_ref_rowctr #(.ROW_W(ROW_W)) u_rowctr (
    .clk(clk), .rst_n(rst_n), .adv(done && ready), .row(row));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req && !refresh_gnt |=> refresh_req);
  // R7
  no_req_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !refresh_req);
  // R8
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  // R4
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own && $past(bus_own) |-> $stable(row_addr));
endmodule

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
  localparam int CLK_NS    = 8;
  localparam int ROWS      = 128;
  localparam int WIN_NS    = ROWS * 50 * CLK_NS;
  localparam int PAUSE_NS  = 2000;
  localparam int INTERVAL  = WIN_NS / ROWS / CLK_NS;      // 50
  localparam int PAUSE_EXP = (PAUSE_NS + CLK_NS - 1) / CLK_NS; // 250
  localparam int SETUP_EXP = 2;   // ceil(10/8)
  localparam int PRE_EXP   = 13;  // ceil(100/8)
  localparam int LOW_EXP   = 22;  // max(ceil(170/8), ceil(270/8)-13)
  localparam int WARM_EXP  = 8;
  localparam int PEND_EXP  = 3;

  logic clk = 1'b0, rst_n = 1'b0, gnt = 1'b0;
  logic refresh_req, ready, bus_own, ras_n;
  logic [7:0] row_addr;

  always #4 clk = ~clk;

  dram_refresh_sched #(
    .CLK_PERIOD_NS(CLK_NS), .REFRESH_WINDOW_NS(WIN_NS), .ROWS(ROWS), .ADDR_W(8),
    .INIT_PAUSE_NS(PAUSE_NS), .WARMUP_PULSES(WARM_EXP), .RAS_LOW_NS(170),
    .RAS_PRE_NS(100), .RAS_CYCLE_NS(270), .CAS_PRE_NS(10), .PEND_MAX(PEND_EXP)
  ) i_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .refresh_gnt(gnt), .refresh_req(refresh_req),
    .ready(ready), .bus_own(bus_own), .ras_n(ras_n), .row_addr(row_addr));

  int checks = 0, fails = 0, cyc = 0, mode = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic bit tick_at(input int c, input int rc);
    return (c > rc) && (((c - rc) % INTERVAL) == 0);
  endfunction

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  bit prev_ras = 1, prev_own = 0, prev_ready = 0, prev_take = 0, ready_seen = 0;
  int hi_cnt = 0, lo_cnt = 0, fall_cnt = 0, ready_cyc = 0, pend = 0, wraps = 0;
  logic [6:0] exp_row = '0;
  logic [7:0] cap_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ready && !ready_seen) begin
        ready_seen = 1; ready_cyc = cyc; pend = 0;
        chk(fall_cnt == WARM_EXP, "R8 warm-up pulses", fall_cnt, WARM_EXP);
      end
      if (prev_ready) chk(ready, "R8 ready sticky", ready, 1);
      if (!ready) chk(!refresh_req, "R7 req before ready", refresh_req, 0);
      if (ready_seen) begin
        if (prev_take && !tick_at(cyc, ready_cyc)) pend--;
        else if (!prev_take && tick_at(cyc, ready_cyc) && pend < PEND_EXP) pend++;
        chk(refresh_req == (pend != 0 && !bus_own), "R1 req vs due", refresh_req, pend != 0 && !bus_own);
        if (bus_own && !prev_own) chk(prev_take, "R3 own without handshake", 0, 1);
      end
      if (bus_own && !prev_own) cap_addr = row_addr;
      if (bus_own && prev_own) chk(row_addr == cap_addr, "R4 addr steady", row_addr, cap_addr);
      if (prev_ras && !ras_n) begin
        chk(hi_cnt == SETUP_EXP, "R6 setup", hi_cnt, SETUP_EXP);
        if (fall_cnt == 0) chk(cyc >= PAUSE_EXP, "R8 pause", cyc, PAUSE_EXP);
        if (ready_seen) begin
          chk(row_addr == {1'b0, exp_row}, "R5 row", row_addr, {1'b0, exp_row});
          if (exp_row == 7'd127) wraps++;
          exp_row = exp_row + 1'b1;
        end
        fall_cnt++; hi_cnt = 0; lo_cnt = 0;
      end
      if (!prev_ras && ras_n) begin
        chk(lo_cnt == LOW_EXP, "R6 low", lo_cnt, LOW_EXP);
        hi_cnt = 0;
      end
      if (prev_own && !bus_own) begin
        chk(hi_cnt == PRE_EXP, "R6 precharge", hi_cnt, PRE_EXP);
        hi_cnt = 0;
      end
      if (!ras_n) lo_cnt++;
      else if (bus_own) hi_cnt++;
      prev_ras = ras_n; prev_own = bus_own; prev_ready = ready;
      case (mode)
        1:       gnt = (($urandom % 3) == 0);
        2:       gnt = 1'b0;
        default: gnt = 1'b1;
      endcase
      prev_take = refresh_req && gnt;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(ras_n == 1'b1, "R10 ras_n", ras_n, 1);
    chk(ready == 1'b0, "R10 ready", ready, 0);
    chk(refresh_req == 1'b0, "R10 req", refresh_req, 0);
    chk(bus_own == 1'b0, "R10 bus_own", bus_own, 0);
    chk(row_addr == 8'd0, "R10 row_addr", row_addr, 0);
    mode = 1;
    rst_n = 1'b1;
    for (int i = 0; i < 2000 && !ready; i++) @(negedge clk);
    chk(ready, "R8 ready reached", ready, 1);
    repeat (140 * INTERVAL) @(negedge clk);
    chk(wraps >= 1, "R5 wrap 127 to 0", wraps, 1);
    mode = 2;
    repeat (12 * INTERVAL) @(negedge clk);
    // R9: surplus dropped, request held while stalled (R2)
    chk(pend == PEND_EXP, "R9 saturated count", pend, PEND_EXP);
    chk(refresh_req, "R2 req held in stall", refresh_req, 1);
    mode = 3;
    repeat (4 * INTERVAL) @(negedge clk);
    mode = 1;
    repeat (10 * INTERVAL) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule